// File: doc/BRIEF.md
# Interrupt enable and mode controller

This block holds the interrupt state of an 8-bit CPU core: two enable flip-flops, a 2-bit interrupt mode register, and a one-instruction hold-off that follows an enable instruction. The instruction decoder sends it one-cycle strobes for disable, enable, set-mode, the two interrupt-return instructions and the transfer of the interrupt or refresh register into the accumulator. The interrupt sequencer sends it acceptance strobes for maskable and non-maskable interrupts.

The block reports the two enable bits and the mode. It also reports whether a pending maskable request may be taken now. For the register-to-accumulator transfer it returns a bundle of flags: sign, zero, half-carry, parity/overflow and subtract. The parity/overflow flag carries the saved enable bit. The ALU, register file, stack and vector fetch are outside the block.

Top module: `intr_state_ctl`

## Requirements
- R1: While `rst_n` is low and after its release, `iff1`=0, `iff2`=0, `imode`=2'b00 and `int_ok`=0.
- R2: A `di_stb` cycle with no acceptance strobe leaves `iff1`=0 and `iff2`=0 after the next clock edge.
- R3: An `ei_stb` cycle with no acceptance strobe and no `di_stb` leaves `iff1`=1 and `iff2`=1 after the next clock edge.
- R4: On `im_stb`, `imode` is loaded from `im_sel` as follows: 0 gives 2'b00, 1 gives 2'b00, 2 gives 2'b01 and 3 gives 2'b10. Without `im_stb`, `imode` holds its value. `imode` is never 2'b11.
- R5: `reti_stb` or `retn_stb`, when it is not combined with di/ei or acceptance, copies `iff2` into `iff1` and leaves `iff2` unchanged.
- R6: During an `ldair_stb` cycle, `flg_valid` is 1 in that same cycle and the flags are driven as follows:
  - `flg_s` equals bit 7 of `ldair_data`.
  - `flg_z` is 1 exactly when `ldair_data` is zero.
  - `flg_pv` equals the current `iff2`.
  - `flg_h` and `flg_n` are 0.
  Outside such a cycle, `flg_valid` and all the flags are 0.
- R7: `int_ok` is 1 exactly when `int_req` is 1, `iff1` is 1 and no enable hold-off is pending.
- R8: After an `ei_stb` cycle, `int_ok` stays 0 until the first `insn_done` in a later cycle. From the cycle after that `insn_done`, `int_ok` follows R7 again.
- R9: `int_ack` clears both `iff1` and `iff2`.
- R10: `nmi_ack` copies `iff1` into `iff2` and clears `iff1`. If `nmi_ack` and `int_ack` arrive together, `nmi_ack` wins.
- R11: An acceptance strobe overrides every instruction strobe in the same cycle:
  - di, ei, ret and im have no effect.
  - `flg_valid` stays 0.
- R12: Reset overrides every strobe. While `rst_n` is low, any strobe leaves the state in its reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| di_stb | input | 1 | Disable-interrupts instruction strobe |
| ei_stb | input | 1 | Enable-interrupts instruction strobe |
| im_stb | input | 1 | Set-mode instruction strobe |
| im_sel | input | 2 | Low two bits of the set-mode opcode selector field |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| retn_stb | input | 1 | Return-from-NMI strobe |
| ldair_stb | input | 1 | Interrupt/refresh register to accumulator transfer strobe |
| ldair_data | input | DATA_W | Byte moved into the accumulator |
| insn_done | input | 1 | Instruction boundary from the decoder |
| int_req | input | 1 | Pending maskable interrupt request |
| int_ack | input | 1 | Maskable interrupt accepted |
| nmi_ack | input | 1 | Non-maskable interrupt accepted |
| iff1 | output | 1 | Live interrupt enable |
| iff2 | output | 1 | Saved interrupt enable |
| imode | output | 2 | Interrupt mode (00, 01, 10) |
| int_ok | output | 1 | Maskable request may be taken now |
| flg_valid | output | 1 | Flag bundle valid |
| flg_s | output | 1 | Sign flag |
| flg_z | output | 1 | Zero flag |
| flg_h | output | 1 | Half-carry flag |
| flg_pv | output | 1 | Parity/overflow flag |
| flg_n | output | 1 | Subtract flag |

## Verification
A corrupted enable bit appears on `iff1`/`iff2` one edge after the strobe that caused it. A wrong `iff2` also shows up one transfer later, in `flg_pv`, and one return later, in `iff1`. A hold-off bit that is stuck or cleared too early becomes visible in `int_ok` in the same cycle as a request. A wrong priority ordering shows up as enable bits or a mode that moved when the acceptance strobe should have frozen them. Randomly mixed strobes are compared with a bench model, so such errors are caught within a few cycles of the first conflicting combination.

// File: rtl/intr_state_ctl.sv
module intr_state_ctl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              di_stb,
  input  logic              ei_stb,
  input  logic              im_stb,
  input  logic [1:0]        im_sel,
  input  logic              reti_stb,
  input  logic              retn_stb,
  input  logic              ldair_stb,
  input  logic [DATA_W-1:0] ldair_data,
  input  logic              insn_done,
  input  logic              int_req,
  input  logic              int_ack,
  input  logic              nmi_ack,
  output logic              iff1,
  output logic              iff2,
  output logic [1:0]        imode,
  output logic              int_ok,
  output logic              flg_valid,
  output logic              flg_s,
  output logic              flg_z,
  output logic              flg_h,
  output logic              flg_pv,
  output logic              flg_n
);

  logic       ei_hold;
  logic       accept;
  logic [1:0] im_code;

  assign accept  = int_ack | nmi_ack;
  assign im_code = im_sel[1] ? {im_sel[0], ~im_sel[0]} : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iff1    <= 1'b0;
      iff2    <= 1'b0;
      ei_hold <= 1'b0;
      imode   <= 2'b00;
    end else if (nmi_ack) begin
      iff2    <= iff1;
      iff1    <= 1'b0;
      ei_hold <= 1'b0;
    end else if (int_ack) begin
      iff1    <= 1'b0;
      iff2    <= 1'b0;
      ei_hold <= 1'b0;
    end else begin
      if (di_stb) begin
        iff1    <= 1'b0;
        iff2    <= 1'b0;
        ei_hold <= 1'b0;
      end else if (ei_stb) begin
        iff1    <= 1'b1;
        iff2    <= 1'b1;
        ei_hold <= 1'b1;
      end else begin
        if (reti_stb || retn_stb) iff1 <= iff2;
        if (insn_done) ei_hold <= 1'b0;
      end
      if (im_stb) imode <= im_code;
    end
  end

  assign int_ok    = int_req & iff1 & ~ei_hold;

  assign flg_valid = rst_n & ldair_stb & ~accept;
  assign flg_s     = flg_valid & ldair_data[DATA_W-1];
  assign flg_z     = flg_valid & (ldair_data == '0);
  assign flg_pv    = flg_valid & iff2;
  assign flg_h     = 1'b0;
  assign flg_n     = 1'b0;

  // R2
  di_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (di_stb && !accept) |=> (!iff1 && !iff2));
  // R3
  ei_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ei_stb && !di_stb && !accept) |=> (iff1 && iff2));
  // R4
  imode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imode != 2'b11);
  // R4
  imode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !im_stb |=> $stable(imode));
  // R5
  ret_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((reti_stb || retn_stb) && !di_stb && !ei_stb && !accept)
    |=> (iff1 == $past(iff2) && $stable(iff2)));
  // R6
  flag_pv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flg_valid |-> (flg_pv == iff2 && !flg_h && !flg_n));
  // R8
  ei_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ei_stb && !di_stb && !accept) |=> !int_ok);
  // R9
  mask_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !nmi_ack) |=> (!iff1 && !iff2));
  // R10
  nmi_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |=> (!iff1 && iff2 == $past(iff1)));
  // R11
  accept_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> $stable(imode));

endmodule

// File: tb/test_intr_state_ctl.sv
`timescale 1ns/1ps
module test_intr_state_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic di_stb = 0, ei_stb = 0, im_stb = 0, reti_stb = 0, retn_stb = 0, ldair_stb = 0;
  logic [1:0] im_sel = 0;
  logic [7:0] ldair_data = 0;
  logic insn_done = 0, int_req = 0, int_ack = 0, nmi_ack = 0;
  logic iff1, iff2, int_ok, flg_valid, flg_s, flg_z, flg_h, flg_pv, flg_n;
  logic [1:0] imode;

  int checks = 0, errors = 0;
  logic m1 = 0, m2 = 0, mh = 0;
  logic [1:0] mm = 0;

  always #2.5 clk = ~clk;

  intr_state_ctl i_intr_state_ctl (
    .clk, .rst_n, .di_stb, .ei_stb, .im_stb, .im_sel, .reti_stb, .retn_stb,
    .ldair_stb, .ldair_data, .insn_done, .int_req, .int_ack, .nmi_ack,
    .iff1, .iff2, .imode, .int_ok, .flg_valid, .flg_s, .flg_z, .flg_h,
    .flg_pv, .flg_n);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] map_mode(input logic [1:0] s);
    case (s)
      2'd2: return 2'b01;
      2'd3: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic clear_in();
    {di_stb, ei_stb, im_stb, reti_stb, retn_stb, ldair_stb} = '0;
    {insn_done, int_req, int_ack, nmi_ack} = '0;
  endtask

  // inputs are already set at a falling edge
  task automatic cycle(input string tag_in);
    string tag;
    logic n1, n2, nh, fv;
    logic [1:0] nm;
    tag = tag_in;
    if (!rst_n) begin m1 = 0; m2 = 0; mh = 0; mm = 0; end
    #1;
    fv = rst_n & ldair_stb & ~(int_ack | nmi_ack);
    chk((tag == "") ? (mh ? "R8" : "R7") : tag, "int_ok", int_ok, int_req & m1 & ~mh);
    chk((tag == "") ? "R6" : tag, "flg_valid", flg_valid, fv);
    chk((tag == "") ? "R6" : tag, "flags", {flg_s, flg_z, flg_h, flg_pv, flg_n},
        fv ? {ldair_data[7], ldair_data == 0, 1'b0, m2, 1'b0} : 5'b0);
    n1 = m1; n2 = m2; nh = mh; nm = mm;
    if (!rst_n) begin
      n1 = 0; n2 = 0; nh = 0; nm = 0; if (tag == "") tag = "R12";
    end else if (nmi_ack) begin
      n2 = m1; n1 = 0; nh = 0; if (tag == "") tag = "R10";
    end else if (int_ack) begin
      n1 = 0; n2 = 0; nh = 0; if (tag == "") tag = "R9";
    end else begin
      if (di_stb) begin
        n1 = 0; n2 = 0; nh = 0; if (tag == "") tag = "R2";
      end else if (ei_stb) begin
        n1 = 1; n2 = 1; nh = 1; if (tag == "") tag = "R3";
      end else begin
        if (reti_stb | retn_stb) begin n1 = m2; if (tag == "") tag = "R5"; end
        if (insn_done) nh = 0;
      end
      if (im_stb) begin nm = map_mode(im_sel); if (tag == "") tag = "R4"; end
    end
    if (tag == "") tag = "R4";
    @(posedge clk);
    m1 = n1; m2 = n2; mh = nh; mm = nm;
    @(negedge clk);
    chk(tag, "iff1", iff1, m1);
    chk(tag, "iff2", iff2, m2);
    chk(tag, "imode", imode, mm);
    clear_in();
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    // R1 reset values
    chk("R1", "iff1", iff1, 0); chk("R1", "iff2", iff2, 0);
    chk("R1", "imode", imode, 0); chk("R1", "int_ok", int_ok, 0);
    // R12 strobes during reset
    ei_stb = 1; im_stb = 1; im_sel = 3; int_req = 1; cycle("R12");
    @(negedge clk); rst_n = 1;
    // R4 each selector value
    for (int s = 3; s >= 0; s--) begin
      @(negedge clk); im_stb = 1; im_sel = s[1:0]; cycle("R4");
    end
    // R3 + R8 hold-off sequence
    @(negedge clk); ei_stb = 1; insn_done = 1; int_req = 1; cycle("R8");
    @(negedge clk); int_req = 1; cycle("R8");
    @(negedge clk); int_req = 1; insn_done = 1; cycle("R8");
    @(negedge clk); int_req = 1; cycle("R7");
    // R6 transfer flags
    @(negedge clk); ldair_stb = 1; ldair_data = 8'h00; cycle("R6");
    @(negedge clk); ldair_stb = 1; ldair_data = 8'h85; cycle("R6");
    // R10 nmi then R5 return
    @(negedge clk); nmi_ack = 1; cycle("R10");
    @(negedge clk); ldair_stb = 1; ldair_data = 8'h40; cycle("R6");
    @(negedge clk); retn_stb = 1; cycle("R5");
    // R11 priority pairs
    @(negedge clk); int_ack = 1; ei_stb = 1; cycle("R11");
    @(negedge clk); ei_stb = 1; cycle("R3");
    @(negedge clk); int_ack = 1; nmi_ack = 1; cycle("R10");
    @(negedge clk); reti_stb = 1; cycle("R5");
    @(negedge clk); ei_stb = 1; cycle("R3");
    @(negedge clk); nmi_ack = 1; di_stb = 1; im_stb = 1; im_sel = 2; ldair_stb = 1; cycle("R11");
    @(negedge clk); int_ack = 1; reti_stb = 1; cycle("R9");
    @(negedge clk); ei_stb = 1; di_stb = 1; cycle("R2");
    // random mix
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      di_stb    = ($urandom_range(0, 9) == 0);
      ei_stb    = ($urandom_range(0, 6) == 0);
      im_stb    = ($urandom_range(0, 7) == 0);
      im_sel    = 2'($urandom_range(0, 3));
      reti_stb  = ($urandom_range(0, 9) == 0);
      retn_stb  = ($urandom_range(0, 9) == 0);
      ldair_stb = ($urandom_range(0, 4) == 0);
      ldair_data = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 5) == 0) ldair_data = 0;
      insn_done = ($urandom_range(0, 2) == 0);
      int_req   = $urandom_range(0, 1);
      int_ack   = ($urandom_range(0, 11) == 0);
      nmi_ack   = ($urandom_range(0, 15) == 0);
      cycle("");
    end
    // R12 reset again mid-run
    @(negedge clk); rst_n = 0; ei_stb = 1; cycle("R12");
    chk("R1", "int_ok", int_ok, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule